// File: doc/BRIEF.md
# UART transmitter with priority queue

This block is the transmit half of one serial channel. Bytes arrive on two write ports. One feeds a deep main FIFO. The other feeds a small priority queue that is always emptied before the main FIFO. A one-byte holding register sits between the queues and the shift register. The shift register sends asynchronous frames at a rate set by a fixed divide-by-10 prescaler followed by a programmable divisor.

The character format is set by a line configuration word: 7 or 8 data bits, parity on or off, odd or even parity, and 1 or 2 stop bits. A modem control word drives break, local loopback, DTR and RTS, and it enables the transmitter. When CTS flow control is on, a deasserted CTS input holds back the start of the next character. Status outputs show when the queues are empty and when the shift register is empty. A channel is drained only when both are set.

Top module: `uart_tx_prio`

## Requirements
- R1: The main FIFO stores up to MAIN_DEPTH (default 255) bytes and the priority queue up to PRIO_DEPTH (default 32). `main_level` and `prio_level` report the number of stored bytes.
- R2: While the priority queue holds any byte, `prio_pending` is 1. Every priority byte is sent before any main FIFO byte that is still waiting.
- R3: `modem_ctl[0]` (transmit enable) gates only the move from the queues into the holding register. After it is cleared, a byte already in the holding register and the byte in the shift register are still sent, so at most two more frames go out.
- R4: The line idles at 1. A frame is one 0 start bit, then the data bits LSB first, then optional parity, then stop bits at 1. `line_cfg[0]`=1 selects 8 data bits and 0 selects 7.
- R5: `line_cfg[2]` enables a parity bit. When `line_cfg[1]`=1 the parity bit makes the count of ones in data plus parity even; when 0 it makes that count odd.
- R6: `line_cfg[3]`=1 sends two stop bits and 0 sends one.
- R7: Each bit lasts 10*(divisor+1) clock cycles.
- R8: When `line_cfg[6]` (CTS flow control) is 1 and `cts` is 0, no new frame starts. A frame already in progress finishes.
- R9: A write to a full main FIFO or a full priority queue is dropped and sets `overflow`. `overflow` stays set until reset.
- R10: `modem_ctl[4]` (break) holds `txd` at 0 for as long as it is set. Clearing it returns the line to 1.
- R11: `fifo_empty` is 1 when both queues and the holding register are empty. `shreg_empty` is 1 when no frame is being shifted.
- R12: `dtr` follows `modem_ctl[2]`. `rts` follows `modem_ctl[1]`, except when `line_cfg[5]` (RTS toggle) is 1; then `rts` is 1 only while a byte is in the holding or shift register. `modem_ctl[3]` (loopback) holds `txd` at 1 and sends the frames on `loop_data` instead.
- R13: `tx_irq` is 1 when `line_cfg[4]` is 1 and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_wr | input | 1 | Write strobe for the main FIFO |
| main_data | input | 8 | Byte for the main FIFO |
| prio_wr | input | 1 | Write strobe for the priority queue |
| prio_data | input | 8 | Byte for the priority queue |
| line_cfg | input | 7 | [6] CTS flow ctl, [5] RTS toggle, [4] irq enable, [3] two stop, [2] parity on, [1] even, [0] 8 bits |
| modem_ctl | input | 5 | [4] break, [3] loopback, [2] DTR, [1] RTS, [0] transmit enable |
| divisor | input | 16 | Baud divisor after the /10 prescaler |
| cts | input | 1 | Clear-to-send, 1 = asserted |
| txd | output | 1 | Serial output |
| loop_data | output | 1 | Serial frames while in loopback |
| dtr | output | 1 | DTR output |
| rts | output | 1 | RTS output |
| shreg_empty | output | 1 | No frame in the shift register |
| fifo_empty | output | 1 | Queues and holding register empty |
| prio_pending | output | 1 | Priority queue not empty |
| tx_irq | output | 1 | Transmit-empty interrupt |
| overflow | output | 1 | Sticky write-drop flag |
| main_level | output | 8 | Bytes in the main FIFO |
| prio_level | output | 6 | Bytes in the priority queue |

## Verification
A decoding monitor rebuilds every frame from the serial line at mid-bit points. It checks each frame against a queue of frames predicted from the byte and the line configuration. Data values with many ones, few ones and mixed bits are sent as 8N1, 7E2 and 8O1 at two divisors. This separates errors in bit order, data width, parity sense, stop count and bit timing. Other sequences test ordering and gating. Priority bytes are written after main bytes while the transmitter is off, so a wrong drain order shows up. Transmit enable is cleared in the middle of a burst to count the leftover frames. CTS is deasserted both before a frame and during one.

// File: rtl/uart_tx_prio.sv
module uart_tx_prio #(
  parameter int MAIN_DEPTH = 255,
  parameter int PRIO_DEPTH = 32,
  parameter int PRESCALE   = 10,
  parameter int DIV_W      = 16,
  localparam int MAIN_AW   = $clog2(MAIN_DEPTH),
  localparam int MAIN_CW   = $clog2(MAIN_DEPTH + 1),
  localparam int PRIO_AW   = $clog2(PRIO_DEPTH),
  localparam int PRIO_CW   = $clog2(PRIO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               main_wr,
  input  logic [7:0]         main_data,
  input  logic               prio_wr,
  input  logic [7:0]         prio_data,
  input  logic [6:0]         line_cfg,
  input  logic [4:0]         modem_ctl,
  input  logic [DIV_W-1:0]   divisor,
  input  logic               cts,
  output logic               txd,
  output logic               loop_data,
  output logic               dtr,
  output logic               rts,
  output logic               shreg_empty,
  output logic               fifo_empty,
  output logic               prio_pending,
  output logic               tx_irq,
  output logic               overflow,
  output logic [MAIN_CW-1:0] main_level,
  output logic [PRIO_CW-1:0] prio_level
);
  localparam logic [MAIN_CW-1:0] MAIN_FULL = MAIN_CW'(MAIN_DEPTH);
  localparam logic [PRIO_CW-1:0] PRIO_FULL = PRIO_CW'(PRIO_DEPTH);
  localparam logic [MAIN_AW-1:0] MAIN_LAST = MAIN_AW'(MAIN_DEPTH - 1);
  localparam logic [PRIO_AW-1:0] PRIO_LAST = PRIO_AW'(PRIO_DEPTH - 1);
  localparam int PRE_W = $clog2(PRESCALE);

  wire cts_fc   = line_cfg[6];
  wire rts_tog  = line_cfg[5];
  wire irq_en   = line_cfg[4];
  wire stop2    = line_cfg[3];
  wire par_en   = line_cfg[2];
  wire par_even = line_cfg[1];
  wire d8       = line_cfg[0];
  wire brk      = modem_ctl[4];
  wire loop_en  = modem_ctl[3];
  wire tx_en    = modem_ctl[0];

  logic [7:0] m_mem [MAIN_DEPTH];
  logic [7:0] p_mem [PRIO_DEPTH];
  logic [MAIN_AW-1:0] m_rd, m_wr;
  logic [PRIO_AW-1:0] p_rd, p_wr;
  logic [MAIN_CW-1:0] m_cnt;
  logic [PRIO_CW-1:0] p_cnt;
  logic hold_v, busy, out_bit;
  logic [7:0] hold_d;
  logic [10:0] sh, pay;
  logic [3:0] bcnt, len_rem;
  logic [PRE_W-1:0] pre;
  logic [DIV_W-1:0] dcnt;

  wire push_m = main_wr && (m_cnt != MAIN_FULL);
  wire push_p = prio_wr && (p_cnt != PRIO_FULL);
  wire load   = !hold_v && tx_en && ((p_cnt != '0) || (m_cnt != '0));
  wire pop_p  = load && (p_cnt != '0);
  wire pop_m  = load && (p_cnt == '0);

  wire pre_wrap  = (pre == PRE_W'(PRESCALE - 1));
  wire tick      = pre_wrap && (dcnt >= divisor);
  wire can_start = hold_v && (!cts_fc || cts);
  wire start     = tick && can_start && (!busy || (bcnt == 4'd0));

  always_ff @(posedge clk) begin
    if (push_m) m_mem[m_wr] <= main_data;
    if (push_p) p_mem[p_wr] <= prio_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_rd <= '0; m_wr <= '0; m_cnt <= '0;
      p_rd <= '0; p_wr <= '0; p_cnt <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_m) m_wr <= (m_wr == MAIN_LAST) ? '0 : m_wr + 1'b1;
      if (pop_m)  m_rd <= (m_rd == MAIN_LAST) ? '0 : m_rd + 1'b1;
      if (push_p) p_wr <= (p_wr == PRIO_LAST) ? '0 : p_wr + 1'b1;
      if (pop_p)  p_rd <= (p_rd == PRIO_LAST) ? '0 : p_rd + 1'b1;
      m_cnt <= m_cnt + MAIN_CW'(push_m) - MAIN_CW'(pop_m);
      p_cnt <= p_cnt + PRIO_CW'(push_p) - PRIO_CW'(pop_p);
      if ((main_wr && !push_m) || (prio_wr && !push_p)) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (start) begin
      hold_v <= 1'b0;
    end else if (load) begin
      hold_v <= 1'b1;
      hold_d <= pop_p ? p_mem[p_rd] : m_mem[m_rd];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      dcnt <= '0;
    end else begin
      pre <= pre_wrap ? '0 : pre + 1'b1;
      if (pre_wrap) dcnt <= (dcnt >= divisor) ? '0 : dcnt + 1'b1;
    end
  end

  wire par_src = d8 ? ^hold_d : ^hold_d[6:0];
  wire par_bit = par_even ? par_src : ~par_src;

  always_comb begin
    pay = '1;
    if (d8) begin
      pay[7:0] = hold_d;
      if (par_en) pay[8] = par_bit;
    end else begin
      pay[6:0] = hold_d[6:0];
      if (par_en) pay[7] = par_bit;
    end
    len_rem = 4'd7 + {3'd0, d8} + {3'd0, par_en} + (stop2 ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      out_bit <= 1'b1;
      sh      <= '1;
      bcnt    <= '0;
    end else begin
      if (tick && busy) begin
        if (bcnt == 4'd0) begin
          busy    <= 1'b0;
          out_bit <= 1'b1;
        end else begin
          out_bit <= sh[0];
          sh      <= {1'b1, sh[10:1]};
          bcnt    <= bcnt - 1'b1;
        end
      end
      if (start) begin
        busy    <= 1'b1;
        out_bit <= 1'b0;
        sh      <= pay;
        bcnt    <= len_rem;
      end
    end
  end

  assign txd          = brk ? 1'b0 : (loop_en ? 1'b1 : out_bit);
  assign loop_data    = out_bit;
  assign dtr          = modem_ctl[2];
  assign rts          = rts_tog ? (busy || hold_v) : modem_ctl[1];
  assign shreg_empty  = !busy;
  assign fifo_empty   = (m_cnt == '0) && (p_cnt == '0) && !hold_v;
  assign prio_pending = (p_cnt != '0);
  assign tx_irq       = irq_en && fifo_empty;
  assign main_level   = m_cnt;
  assign prio_level   = p_cnt;

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cnt <= MAIN_FULL) && (p_cnt <= PRIO_FULL));

  assert_prio_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !$past(hold_v) && ($past(p_cnt) != '0) && !$past(prio_wr))
      |-> (p_cnt == $past(p_cnt) - 1'b1));

  assert_hold_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !hold_v) |=> !hold_v);

  assert_cts_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cts_fc) || $past(cts)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow);
endmodule

// File: tb/uart_tx_prio_test.sv
module uart_tx_prio_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, main_wr, prio_wr, cts;
  logic [7:0] main_data, prio_data;
  logic [6:0] lcfg;
  logic [4:0] mctl;
  logic [15:0] divisor;
  logic txd, loop_data, dtr, rts, shreg_empty, fifo_empty, prio_pending, tx_irq, overflow;
  logic [7:0] main_level;
  logic [5:0] prio_level;

  uart_tx_prio uut (
    .clk(clk), .rst_n(rst_n), .main_wr(main_wr), .main_data(main_data),
    .prio_wr(prio_wr), .prio_data(prio_data), .line_cfg(lcfg), .modem_ctl(mctl),
    .divisor(divisor), .cts(cts), .txd(txd), .loop_data(loop_data), .dtr(dtr),
    .rts(rts), .shreg_empty(shreg_empty), .fifo_empty(fifo_empty),
    .prio_pending(prio_pending), .tx_irq(tx_irq), .overflow(overflow),
    .main_level(main_level), .prio_level(prio_level)
  );

  int n_tests = 0, n_fail = 0;
  int cur_div = 0;
  bit mon_on = 1'b1, mon_loop = 1'b0, mon_busy = 1'b0;
  logic [15:0] sb[$];
  logic [15:0] mon_e;
  logic [11:0] mon_got, mon_mask;
  int mon_len, mon_bp;
  bit saw_low;

  function automatic logic [15:0] mk_frame(input logic [7:0] b, input logic [6:0] c);
    logic [11:0] v;
    int n;
    logic p;
    v = '1; n = 0;
    v[n] = 1'b0; n++;
    for (int i = 0; i < (c[0] ? 8 : 7); i++) begin v[n] = b[i]; n++; end
    if (c[2]) begin
      p = c[0] ? ^b : ^b[6:0];
      v[n] = c[1] ? p : ~p;
      n++;
    end
    n += c[3] ? 2 : 1;
    return {n[3:0], v};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic mon_line();
    return mon_loop ? loop_data : txd;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mon_on && mon_line() == 1'b0) begin
      mon_busy = 1'b1;
      mon_bp = 10 * (cur_div + 1);
      if (sb.size() == 0) begin
        mon_e = 16'hA000;
        chk(1'b0, "R4 unexpected frame", 1, 0);
      end else mon_e = sb.pop_front();
      mon_len = int'(mon_e[15:12]);
      mon_got = '1;
      repeat (mon_bp / 2) @(negedge clk);
      mon_got[0] = mon_line();
      for (int k = 1; k < mon_len; k++) begin
        repeat (mon_bp) @(negedge clk);
        mon_got[k] = mon_line();
      end
      mon_mask = 12'hFFF >> (12 - mon_len);
      chk((mon_got & mon_mask) == (mon_e[11:0] & mon_mask),
          "R4 R5 R6 R7 frame bits", int'(mon_got & mon_mask), int'(mon_e[11:0] & mon_mask));
      mon_busy = 1'b0;
    end
  end

  task automatic wr_m(input logic [7:0] b, input bit expect_it);
    @(negedge clk);
    main_wr = 1'b1; main_data = b;
    if (expect_it) sb.push_back(mk_frame(b, lcfg));
    @(negedge clk);
    main_wr = 1'b0;
  endtask

  task automatic wr_p(input logic [7:0] b, input bit expect_it);
    @(negedge clk);
    prio_wr = 1'b1; prio_data = b;
    if (expect_it) sb.push_back(mk_frame(b, lcfg));
    @(negedge clk);
    prio_wr = 1'b0;
  endtask

  task automatic wait_drain();
    int t = 0;
    while ((sb.size() != 0 || mon_busy || !shreg_empty) && t < 20000) begin
      @(negedge clk); t++;
    end
    chk(t < 20000, "R11 drain", t, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_busy();
    int t = 0;
    while (shreg_empty && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R11 frame start", t, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; main_wr = 1'b0; prio_wr = 1'b0; main_data = '0; prio_data = '0;
    cts = 1'b1; divisor = '0; lcfg = '0; mctl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(txd == 1'b1, "R4 idle line", txd, 1);
    chk(shreg_empty && fifo_empty, "R11 reset status", {shreg_empty, fifo_empty}, 3);
    chk(overflow == 1'b0, "R9 reset flag", overflow, 0);
    chk(main_level == 0 && prio_level == 0, "R1 reset levels", main_level, 0);

    // R4 R7: 8N1 at divisor 0
    lcfg = 7'h01; mctl = 5'h01;
    wr_m(8'hA5, 1); wr_m(8'h3C, 1); wr_m(8'h00, 1); wr_m(8'hFF, 1);
    wait_drain();
    chk(fifo_empty, "R11 empty after drain", fifo_empty, 1);

    // R5 R6 R7: 7E2 at divisor 2, then 8O1
    cur_div = 2; divisor = 16'd2; lcfg = 7'h0E;
    wr_m(8'h55, 1); wr_m(8'h7F, 1); wr_m(8'h01, 1);
    wait_drain();
    lcfg = 7'h05;
    wr_m(8'h80, 1); wr_m(8'h13, 1);
    wait_drain();
    cur_div = 0; divisor = 16'd0; lcfg = 7'h01;

    // R2: priority bytes overtake main bytes
    mctl = 5'h00;
    wr_m(8'h11, 0); wr_m(8'h22, 0); wr_m(8'h33, 0);
    wr_p(8'hE1, 1); wr_p(8'hE2, 1);
    chk(prio_pending == 1'b1, "R2 pending flag", prio_pending, 1);
    chk(main_level == 3 && prio_level == 2, "R1 levels", main_level, 3);
    sb.push_back(mk_frame(8'h11, lcfg));
    sb.push_back(mk_frame(8'h22, lcfg));
    sb.push_back(mk_frame(8'h33, lcfg));
    mctl = 5'h01;
    wait_drain();
    chk(prio_pending == 1'b0, "R2 pending cleared", prio_pending, 0);

    // R3: disabling leaves only held + shifting bytes
    wr_m(8'h40, 1); wr_m(8'h41, 1); wr_m(8'h42, 0); wr_m(8'h43, 0); wr_m(8'h44, 0);
    wait_busy();
    repeat (3) @(negedge clk);
    mctl = 5'h00;
    wait_drain();
    repeat (300) @(negedge clk);
    chk(shreg_empty && main_level == 3, "R3 two bytes after disable", main_level, 3);
    sb.push_back(mk_frame(8'h42, lcfg));
    sb.push_back(mk_frame(8'h43, lcfg));
    sb.push_back(mk_frame(8'h44, lcfg));
    mctl = 5'h01;
    wait_drain();

    // R8: CTS flow control
    lcfg = 7'h41; cts = 1'b0;
    wr_m(8'h5A, 1);
    repeat (300) @(negedge clk);
    chk(shreg_empty && txd, "R8 held by cts", {shreg_empty, txd}, 3);
    chk(fifo_empty == 1'b0, "R11 byte waiting", fifo_empty, 0);
    cts = 1'b1;
    wait_drain();
    wr_m(8'h66, 1); wr_m(8'h77, 0);
    wait_busy();
    cts = 1'b0;
    wait_drain();
    repeat (300) @(negedge clk);
    chk(shreg_empty && !fifo_empty, "R8 frame finished, next held", {shreg_empty, fifo_empty}, 2);
    sb.push_back(mk_frame(8'h77, lcfg));
    cts = 1'b1;
    wait_drain();

    // R12: modem outputs and RTS toggle
    lcfg = 7'h01; mctl = 5'h07;
    @(negedge clk);
    chk(dtr && rts, "R12 dtr rts set", {dtr, rts}, 3);
    mctl = 5'h01;
    @(negedge clk);
    chk(!dtr && !rts, "R12 dtr rts clear", {dtr, rts}, 0);
    lcfg = 7'h21;
    @(negedge clk);
    chk(rts == 1'b0, "R12 toggle idle", rts, 0);
    wr_m(8'h99, 1);
    wait_busy();
    chk(rts == 1'b1, "R12 toggle active", rts, 1);
    wait_drain();
    chk(rts == 1'b0, "R12 toggle after", rts, 0);

    // R12: loopback
    lcfg = 7'h01; mctl = 5'h09; mon_loop = 1'b1;
    wr_m(8'hC3, 1);
    wait_busy();
    saw_low = 1'b0;
    repeat (200) begin @(negedge clk); if (txd == 1'b0) saw_low = 1'b1; end
    chk(saw_low == 1'b0, "R12 loopback keeps txd high", saw_low, 0);
    wait_drain();
    mon_loop = 1'b0; mctl = 5'h01;

    // R10: break
    mon_on = 1'b0; mctl = 5'h11;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R10 break on", txd, 0);
    repeat (500) @(negedge clk);
    chk(txd == 1'b0, "R10 break held", txd, 0);
    mctl = 5'h01;
    @(negedge clk);
    chk(txd == 1'b1, "R10 break cleared", txd, 1);
    repeat (5) @(negedge clk);
    mon_on = 1'b1;

    // R13: interrupt on empty
    lcfg = 7'h11;
    @(negedge clk);
    chk(tx_irq == 1'b1, "R13 irq when empty", tx_irq, 1);
    mctl = 5'h00;
    wr_m(8'h01, 0);
    chk(tx_irq == 1'b0 && !fifo_empty, "R13 irq drops with data", tx_irq, 0);

    // R9 R1: overflow on both queues
    for (int i = 0; i < 256; i++) wr_m(i[7:0], 0);
    chk(main_level == 255, "R1 main full", main_level, 255);
    chk(overflow == 1'b1, "R9 main overflow", overflow, 1);
    repeat (50) @(negedge clk);
    chk(overflow == 1'b1, "R9 sticky", overflow, 1);
    do_reset();
    chk(overflow == 1'b0 && main_level == 0, "R9 cleared by reset", overflow, 0);
    for (int i = 0; i < 33; i++) wr_p(i[7:0], 0);
    chk(prio_level == 32, "R1 prio full", prio_level, 32);
    chk(overflow == 1'b1, "R9 prio overflow", overflow, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule